// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a parameterised set of interrupt sources into one request line for a processor. Each source is fixed at build time, through a bit mask, as level-sensitive or rising-edge-sensitive. Edge-sensitive sources are first passed through a synchronizer chain, so they may come from another clock domain.

Software works through eight word-wide registers on a plain select/write bus. Those registers let it see which sources have fired, enable or mask each source, and clear serviced sources with write-one semantics. A vector register returns the index of the lowest-numbered pending source. A master control word gates the output request. While hardware interrupts are not yet armed, that control word also lets software inject interrupts for self-test.

The output request is built in one of two forms, chosen by a parameter. It is either a one-cycle pulse each time a request appears, or a level that holds until the pending interrupts are acknowledged.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, status, enable and master control read 0, the vector reads 0xFFFFFFFF and irq_req is 0.
- R2: A level source held high is latched into status bit i at the next clock edge. The bit stays set after the source drops, until it is acknowledged.
- R3: An edge source sets its status bit at the third clock edge after it rises. It sets the bit once per rising edge, and a source held high does not set the bit again after an acknowledge.
- R4: Writing the acknowledge register (offset 0x0C) clears each status bit (offset 0x00) written as 1. Bits written as 0 keep their value.
- R5: Writing offset 0x10 sets the enable bits (offset 0x08) written as 1, and writing offset 0x14 clears them. All other enable bits are unchanged. A write to 0x08 loads the enable register directly.
- R6: The pending register (offset 0x04) reads status AND enable.
- R7: The vector register (offset 0x18) reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when nothing is pending.
- R8: In level mode, irq_req rises one edge after pending is nonzero with master bit 0 (offset 0x1C) set. It falls one edge after pending becomes zero or master bit 0 is cleared.
- R9: In pulse mode, irq_req is high for exactly one cycle, one edge after a request first appears.
- R10: A write to status ORs the written ones into status only while master bit 1 is 0. Master bit 1, once written as 1, stays set until reset. Master bit 0 can be written freely.
- R11: Offsets 0x0C, 0x10 and 0x14 read as 0. An address outside the 32-byte window at BASE_ADDR reads 0 and has no effect when written.
- R12: Register bits at or above NUM_IN read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| irq_src | input | NUM_IN | Interrupt sources |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
A corrupted status or enable bit shows up at once in the pending and vector reads, and one edge later on irq_req. A wrong synchronizer depth moves the status set edge for edge sources off the third edge, which a read at each edge catches. A lost sticky bit or a stray inject path shows up as a changed status or master value on the next read after the offending write.

// File: rtl/irq_vec_pkg.sv
// Package: shared register selectors and write strobes for the interrupt
// controller. Assumes a 32-byte register window of eight word registers.
package irq_vec_pkg;

    typedef enum logic [2:0] {
        SEL_STAT  = 3'd0,
        SEL_PEND  = 3'd1,
        SEL_ENAB  = 3'd2,
        SEL_ACK   = 3'd3,
        SEL_SETEN = 3'd4,
        SEL_CLREN = 3'd5,
        SEL_VEC   = 3'd6,
        SEL_MSTR  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic stat;
        logic ack;
        logic enab;
        logic seten;
        logic clren;
        logic mstr;
    } wr_strobe_t;

    localparam int WIN_BITS = 5;

endpackage

// File: rtl/irq_detect.sv
// Module: per-source detection. A source whose EDGE_MASK bit is set passes
// through SYNC_STAGES flops and gives a one-cycle pulse on a rising edge.
// Other sources are passed through as levels; they are assumed synchronous.
module irq_detect #(
    parameter int               NUM_IN      = 8,
    parameter logic [NUM_IN-1:0] EDGE_MASK  = '0,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] src_i,
    output logic [NUM_IN-1:0] det_o
);

    for (genvar i = 0; i < NUM_IN; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            logic [SYNC_STAGES-1:0] sync_q;
            logic                   prev_q;

            // Shift the source through the synchronizer and keep the last value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q <= '0;
                    prev_q <= 1'b0;
                end else begin
                    sync_q <= {sync_q[SYNC_STAGES-2:0], src_i[i]};
                    prev_q <= sync_q[SYNC_STAGES-1];
                end
            end

            // Report a rising edge of the synchronized source.
            always_comb det_o[i] = sync_q[SYNC_STAGES-1] & ~prev_q;
        end else begin : g_level
            // Pass the level through.
            always_comb det_o[i] = src_i[i];
        end
    end

endmodule

// File: rtl/irq_regfile.sv
// Module: register file. Decodes the bus, holds status, enable and master
// control, and forms pending and the vector. Assumes BASE_ADDR is aligned to
// 32 bytes and NUM_IN <= DATA_W.
module irq_regfile
    import irq_vec_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 32,
    parameter int                NUM_IN    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_IN-1:0] det_i,
    output logic [NUM_IN-1:0] pend_o,
    output logic              me_o
);

    localparam int VEC_NONE_W = DATA_W;

    logic [NUM_IN-1:0] status_q, status_d;
    logic [NUM_IN-1:0] enable_q, enable_d;
    logic              me_q, hie_q;
    logic              hit;
    reg_sel_e          rsel;
    wr_strobe_t        ws;
    logic [NUM_IN-1:0] wd;
    logic [DATA_W-1:0] vector;

    // Decode the window hit and the register selected.
    always_comb begin
        hit  = bus_sel
            && (bus_addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS])
            && (bus_addr[1:0] == 2'b00);
        rsel = reg_sel_e'(bus_addr[WIN_BITS-1:2]);
        wd   = bus_wdata[NUM_IN-1:0];
    end

    // Form one write strobe per writable register.
    always_comb begin
        ws       = '0;
        ws.stat  = hit && bus_wr && (rsel == SEL_STAT);
        ws.ack   = hit && bus_wr && (rsel == SEL_ACK);
        ws.enab  = hit && bus_wr && (rsel == SEL_ENAB);
        ws.seten = hit && bus_wr && (rsel == SEL_SETEN);
        ws.clren = hit && bus_wr && (rsel == SEL_CLREN);
        ws.mstr  = hit && bus_wr && (rsel == SEL_MSTR);
    end

    // Next status: inject, acknowledge, then hardware detection wins.
    always_comb begin
        status_d = status_q;
        if (ws.stat && !hie_q) status_d = status_d | wd;
        if (ws.ack)            status_d = status_d & ~wd;
        status_d = status_d | det_i;
    end

    // Next enable: direct load or write-one set/clear aliases.
    always_comb begin
        enable_d = enable_q;
        if (ws.enab)  enable_d = wd;
        if (ws.seten) enable_d = enable_q | wd;
        if (ws.clren) enable_d = enable_q & ~wd;
    end

    // Hold status, enable and master control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
            me_q     <= 1'b0;
            hie_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
            if (ws.mstr) begin
                me_q  <= bus_wdata[0];
                hie_q <= hie_q | bus_wdata[1];
            end
        end
    end

    // Pending sources and master gate.
    always_comb begin
        pend_o = status_q & enable_q;
        me_o   = me_q;
    end

    // Lowest-numbered pending source, all ones when none.
    always_comb begin
        vector = {VEC_NONE_W{1'b1}};
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (pend_o[i]) vector = DATA_W'(i);
        end
    end

    // Read multiplexer; unused bits and write-only aliases read 0.
    always_comb begin
        bus_rdata = '0;
        if (hit && !bus_wr) begin
            case (rsel)
                SEL_STAT: bus_rdata[NUM_IN-1:0] = status_q;
                SEL_PEND: bus_rdata[NUM_IN-1:0] = pend_o;
                SEL_ENAB: bus_rdata[NUM_IN-1:0] = enable_q;
                SEL_VEC:  bus_rdata = vector;
                SEL_MSTR: bus_rdata[1:0] = {hie_q, me_q};
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R4: acknowledged bits are clear next cycle unless re-detected.
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ws.ack && ((wd & det_i) == '0)) |=> ((status_q & $past(wd)) == '0));

    // R5: set-enable alias leaves the written ones set.
    assert_seten_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ws.seten |=> ((enable_q & $past(wd)) == $past(wd)));

    // R5: clear-enable alias leaves the written ones clear.
    assert_clren_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ws.clren |=> ((enable_q & $past(wd)) == '0));

    // R10: the hardware-interrupt arm bit is sticky.
    assert_hie_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hie_q |=> hie_q);

    // R7: a valid vector always names an existing pending source.
    assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vector != {VEC_NONE_W{1'b1}}) |-> ((vector < DATA_W'(NUM_IN)) && pend_o[vector[$clog2(NUM_IN+1)-1:0]]));

endmodule

// File: rtl/irq_req_gen.sv
// Module: request generator. Forms the processor request from pending and the
// master gate, as a registered level or a registered one-cycle pulse.
module irq_req_gen #(
    parameter int NUM_IN    = 8,
    parameter bit PULSE_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] pend_i,
    input  logic              me_i,
    output logic              irq_o
);

    logic active;

    // A request exists when something is pending and the master gate is on.
    always_comb active = (|pend_i) && me_i;

    if (PULSE_OUT) begin : g_pulse
        logic active_q;

        // Emit one cycle on the rising edge of the request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active_q <= 1'b0;
                irq_o    <= 1'b0;
            end else begin
                active_q <= active;
                irq_o    <= active && !active_q;
            end
        end

        // R9: a pulse never lasts two cycles.
        assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |=> !irq_o);
    end else begin : g_level
        // Register the request as a level.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= active;
        end
    end

endmodule

// File: rtl/irq_vec_ctrl.sv
// Module: top of the vectored interrupt controller. Connects detection, the
// register file and the request generator. Assumes NUM_IN <= DATA_W.
module irq_vec_ctrl #(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 32,
    parameter int                NUM_IN    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter logic [NUM_IN-1:0] EDGE_MASK = '0,
    parameter bit                PULSE_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_IN-1:0] irq_src,
    output logic              irq_req
);

    localparam int SYNC_STAGES = 2;

    logic [NUM_IN-1:0] det;
    logic [NUM_IN-1:0] pend;
    logic              me;

    irq_detect #(
        .NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK), .SYNC_STAGES(SYNC_STAGES)
    ) u_detect (
        .clk(clk), .rst_n(rst_n), .src_i(irq_src), .det_o(det)
    );

    irq_regfile #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_IN(NUM_IN), .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .det_i(det), .pend_o(pend), .me_o(me)
    );

    irq_req_gen #(
        .NUM_IN(NUM_IN), .PULSE_OUT(PULSE_OUT)
    ) u_gen (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .me_i(me), .irq_o(irq_req)
    );

    // R8: a request is raised only if the master gate was on the edge before.
    assert_irq_needs_me_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(me));

endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int NI = 8;
    localparam logic [AW-1:0] BASE = 32'h0000_1000;
    localparam int NV = 23;

    // Vector: {op(1=write,2=read-check), requirement, offset, data}
    localparam logic [47:0] VEC [NV] = '{
        {4'h1, 4'd5,  8'h10, 32'h0000_0005},  // R5 set-enable
        {4'h2, 4'd5,  8'h08, 32'h0000_0005},
        {4'h1, 4'd5,  8'h10, 32'h0000_0002},
        {4'h2, 4'd5,  8'h08, 32'h0000_0007},
        {4'h1, 4'd5,  8'h14, 32'h0000_0004},  // R5 clear-enable
        {4'h2, 4'd5,  8'h08, 32'h0000_0003},
        {4'h1, 4'd12, 8'h08, 32'hFFFF_FFFF},  // R12 upper bits
        {4'h2, 4'd12, 8'h08, 32'h0000_00FF},
        {4'h1, 4'd5,  8'h08, 32'h0000_000C},
        {4'h2, 4'd5,  8'h08, 32'h0000_000C},
        {4'h1, 4'd10, 8'h00, 32'h0000_0028},  // R10 inject while unarmed
        {4'h2, 4'd10, 8'h00, 32'h0000_0028},
        {4'h2, 4'd6,  8'h04, 32'h0000_0008},  // R6 pending
        {4'h2, 4'd7,  8'h18, 32'h0000_0003},  // R7 vector
        {4'h1, 4'd4,  8'h0C, 32'h0000_0008},  // R4 acknowledge
        {4'h2, 4'd4,  8'h00, 32'h0000_0020},
        {4'h2, 4'd6,  8'h04, 32'h0000_0000},
        {4'h2, 4'd7,  8'h18, 32'hFFFF_FFFF},
        {4'h2, 4'd11, 8'h0C, 32'h0000_0000},  // R11 write-only reads
        {4'h2, 4'd11, 8'h10, 32'h0000_0000},
        {4'h2, 4'd11, 8'h14, 32'h0000_0000},
        {4'h1, 4'd4,  8'h0C, 32'h0000_0020},
        {4'h2, 4'd4,  8'h00, 32'h0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata, rdata_p;
    logic [NI-1:0] irq_src = '0;
    logic          irq_lvl, irq_pls;
    int            n_run = 0;
    int            n_fail = 0;
    logic [DW-1:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vec_ctrl #(.DATA_W(DW), .ADDR_W(AW), .NUM_IN(NI), .BASE_ADDR(BASE),
                   .EDGE_MASK(8'hF0), .PULSE_OUT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_req(irq_lvl));

    irq_vec_ctrl #(.DATA_W(DW), .ADDR_W(AW), .NUM_IN(NI), .BASE_ADDR(BASE),
                   .EDGE_MASK(8'hF0), .PULSE_OUT(1'b1)) u_dut_pulse (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_p),
        .irq_src(irq_src), .irq_req(irq_pls));

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Starts at a negedge, commits on the next posedge, ends at a negedge.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);

        // R1 reset state
        rd_reg(BASE + 32'h00, rd); chk("R1 status", rd, 32'h0);
        rd_reg(BASE + 32'h08, rd); chk("R1 enable", rd, 32'h0);
        rd_reg(BASE + 32'h1C, rd); chk("R1 master", rd, 32'h0);
        rd_reg(BASE + 32'h18, rd); chk("R1 vector", rd, 32'hFFFF_FFFF);
        chk("R1 irq_req", {31'b0, irq_lvl}, 32'h0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][47:44] == 4'h1) begin
                @(negedge clk);
                wr(BASE + AW'(VEC[k][39:32]), VEC[k][31:0]);
            end else begin
                rd_reg(BASE + AW'(VEC[k][39:32]), rd);
                chk($sformatf("R%0d table %0d", VEC[k][43:40], k), rd, VEC[k][31:0]);
            end
        end

        // R11 out-of-window access
        @(negedge clk);
        wr(BASE + 32'h28, 32'h0);
        rd_reg(BASE + 32'h08, rd); chk("R11 stray write", rd, 32'h0C);
        rd_reg(BASE + 32'h28, rd); chk("R11 stray read", rd, 32'h0);

        // Arm: enable 0..4, master on with hardware armed
        @(negedge clk);
        wr(BASE + 32'h08, 32'h1F);
        wr(BASE + 32'h1C, 32'h3);

        // R2 / R8 / R9 level source
        irq_src = 8'h02;
        edges(1);
        rd_reg(BASE + 32'h00, rd); chk("R2 latch", rd, 32'h02);
        chk("R8 not yet", {31'b0, irq_lvl}, 32'h0);
        chk("R9 not yet", {31'b0, irq_pls}, 32'h0);
        edges(1);
        chk("R8 level high", {31'b0, irq_lvl}, 32'h1);
        chk("R9 pulse high", {31'b0, irq_pls}, 32'h1);
        edges(1);
        chk("R8 level holds", {31'b0, irq_lvl}, 32'h1);
        chk("R9 pulse ends", {31'b0, irq_pls}, 32'h0);
        irq_src = 8'h00;
        edges(1);
        rd_reg(BASE + 32'h00, rd); chk("R2 held after drop", rd, 32'h02);
        rd_reg(BASE + 32'h18, rd); chk("R7 vector 1", rd, 32'h1);
        @(negedge clk);
        wr(BASE + 32'h0C, 32'h0);
        rd_reg(BASE + 32'h00, rd); chk("R4 zero ack", rd, 32'h02);
        @(negedge clk);
        wr(BASE + 32'h0C, 32'h2);
        rd_reg(BASE + 32'h00, rd); chk("R4 ack clears", rd, 32'h0);
        chk("R8 level one more edge", {31'b0, irq_lvl}, 32'h1);
        edges(1);
        chk("R8 level falls", {31'b0, irq_lvl}, 32'h0);

        // R3 edge source bit 4
        @(negedge clk);
        irq_src = 8'h10;
        edges(2);
        rd_reg(BASE + 32'h00, rd); chk("R3 not before third edge", rd, 32'h0);
        edges(1);
        rd_reg(BASE + 32'h00, rd); chk("R3 set on third edge", rd, 32'h10);
        @(negedge clk);
        wr(BASE + 32'h0C, 32'h10);
        edges(3);
        rd_reg(BASE + 32'h00, rd); chk("R3 held source no relatch", rd, 32'h0);
        irq_src = 8'h00;

        // R10 inject blocked once armed; arm bit sticky
        @(negedge clk);
        wr(BASE + 32'h00, 32'h01);
        rd_reg(BASE + 32'h00, rd); chk("R10 inject blocked", rd, 32'h0);
        @(negedge clk);
        wr(BASE + 32'h1C, 32'h1);
        rd_reg(BASE + 32'h1C, rd); chk("R10 arm sticky", rd, 32'h3);

        // R8 master gate removes request
        @(negedge clk);
        irq_src = 8'h01;
        edges(2);
        chk("R8 high with master", {31'b0, irq_lvl}, 32'h1);
        wr(BASE + 32'h1C, 32'h2);
        edges(1);
        chk("R8 gated off", {31'b0, irq_lvl}, 32'h0);
        rd_reg(BASE + 32'h04, rd); chk("R6 still pending", rd, 32'h1);
        irq_src = 8'h00;

        edges(2);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule